// File: doc/BRIEF.md
# Cache Array Test Access Port

This block is a small register-bus slave that lets privileged software reach the data array and the tag array of an L1 data cache directly, without going through the hit/miss path. Software stages a 64-bit value in two 32-bit data registers and then writes a command word. The command picks the array, the direction, the way and the set, and starts exactly one access on the array port. For a read, the array word is returned into the same data registers two cycles after the command write. Software then reads it from there.

Two gates apply. Only requests marked privileged (supervisor or emulation) may touch the registers. A command is only carried out while the memory controller state has the data memory enabled, the configuration field set to cache, and the protection lookup switched off. The cache arrays are outside the block. They are expected to behave as synchronous RAMs that return read data one cycle after a request.

Top module: `cache_test_port`

## Requirements
- R1: A privileged write to the command register (address 0) with bit 0 set, while idle and enabled, drives `arr_req` high for exactly one cycle, starting in the cycle after the write edge. A command with bit 0 clear starts nothing.
- R2: Command word fields are: bit 1 selects the direction (0 read, 1 write), bit 2 selects the array (0 data, 1 tag), bits 4:3 select the way and bits 15:5 select the set. These fields appear on `arr_we`, `arr_tag`, `arr_way` and `arr_set` during the request.
- R3: On a data-array write, `arr_wdata` carries data register 0 (address 1) in bits 31:0 and data register 1 (address 2) in bits 63:32. Both values are taken as staged before the command write.
- R4: On a data-array read, the array word is captured two clock edges after the command write edge: bits 31:0 into data register 0 and bits 63:32 into data register 1.
- R5: On a tag-array access only data register 0 is used. A tag write drives `arr_wdata[63:32]` to zero. A tag read loads only data register 0 and leaves data register 1 unchanged.
- R6: When `bus_priv` is 0, a write changes no register and starts no access. A read returns zero. Either access raises `bus_err` in that cycle.
- R7: A command is ignored unless `mc_mem_en` is 1, `mc_cfg` is 2'b11 and `mc_prot_en` is 0.
- R8: Bit 31 of the command register readback is a busy flag. It is set from the command write edge until the completing edge two cycles later. Data register reads during busy return the previous contents.
- R9: A command write that arrives while busy is dropped: the stored command and the array port are unaffected.
- R10: After reset, all registers read zero and `arr_req` is low.
- R11: Reads of address 3 return zero without error. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | 0 command, 1 data low, 2 data high |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Requester is supervisor or emulation |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Access refused for privilege |
| mc_mem_en | input | 1 | L1 data memory enable |
| mc_cfg | input | 2 | Memory configuration, 2'b11 is cache |
| mc_prot_en | input | 1 | Protection lookup enable |
| arr_req | output | 1 | Array access strobe |
| arr_we | output | 1 | Array write |
| arr_tag | output | 1 | Tag array selected |
| arr_way | output | 2 | Way |
| arr_set | output | 11 | Set index |
| arr_wdata | output | 64 | Array write data |
| arr_rdata | input | 64 | Array read data, one cycle after request |

## Verification
The bench writes a 64-bit pattern with distinct halves to one way and set, then reads it back. This separates a half swap from a correct mapping. Reading a different way of the same set tells way decoding apart from set decoding. Tag accesses use a tag RAM model that returns non-zero upper bits and a data register 1 loaded with a marker, so a spurious upper capture is visible. Each disabling memory-control state, a cleared enable bit, an unprivileged requester and a command while busy are each applied alone, so each gate is shown to block on its own.

// File: rtl/ctp_pkg.sv
// Package: shared widths, command layout and sequencer states for the
// cache array test port. Assumes a 16-bit command word and 32-bit bus.
package ctp_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned WAY_W  = 2;
    localparam int unsigned SET_W  = 11;
    localparam int unsigned CMD_W  = SET_W + WAY_W + 3;
    localparam int unsigned LINE_W = 2 * WORD_W;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CMD = 2'd0;
    localparam logic [ADDR_W-1:0] A_DLO = 2'd1;
    localparam logic [ADDR_W-1:0] A_DHI = 2'd2;

    localparam logic [1:0] MC_CFG_CACHE = 2'b11;

    typedef struct packed {
        logic [SET_W-1:0] set;
        logic [WAY_W-1:0] way;
        logic             tag;
        logic             write;
        logic             go;
    } cmd_t;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ISSUE   = 2'd1,
        SEQ_CAPTURE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ctp_regbus.sv
// Module: register bus decode and privilege filter.
// Assumes single-cycle accesses; read data is combinational.
module ctp_regbus
    import ctp_pkg::*;
(
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_priv,
    input  logic                  busy,
    input  logic [CMD_W-1:0]      cmd_q,
    input  logic [WORD_W-1:0]     dlo_q,
    input  logic [WORD_W-1:0]     dhi_q,
    output logic                  wr_cmd,
    output logic                  wr_dlo,
    output logic                  wr_dhi,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  bus_err
);
    logic ok_wr;
    logic ok_rd;

    // Purpose: qualify accesses by privilege.
    always_comb begin
        ok_wr   = bus_sel && bus_wr && bus_priv;
        ok_rd   = bus_sel && !bus_wr && bus_priv;
        bus_err = bus_sel && !bus_priv;
    end

    // Purpose: per-register write strobes.
    always_comb begin
        wr_cmd = ok_wr && (bus_addr == A_CMD);
        wr_dlo = ok_wr && (bus_addr == A_DLO);
        wr_dhi = ok_wr && (bus_addr == A_DHI);
    end

    // Purpose: read mux, zero when refused or unmapped.
    always_comb begin
        bus_rdata = '0;
        if (ok_rd) begin
            case (bus_addr)
                A_CMD: begin
                    bus_rdata[CMD_W-1:0]  = cmd_q;
                    bus_rdata[WORD_W-1]   = busy;
                end
                A_DLO:   bus_rdata = dlo_q;
                A_DHI:   bus_rdata = dhi_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ctp_seq.sv
// Module: command register and array access sequencer.
// Assumes the array returns read data one cycle after arr_req.
module ctp_seq
    import ctp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_cmd,
    input  logic [CMD_W-1:0]      cmd_wdata,
    input  logic                  mem_ok,
    input  logic [WORD_W-1:0]     dlo_q,
    input  logic [WORD_W-1:0]     dhi_q,
    output logic [CMD_W-1:0]      cmd_q,
    output logic                  busy,
    output logic                  arr_req,
    output logic                  arr_we,
    output logic                  arr_tag,
    output logic [WAY_W-1:0]      arr_way,
    output logic [SET_W-1:0]      arr_set,
    output logic [LINE_W-1:0]     arr_wdata,
    output logic                  cap_lo,
    output logic                  cap_hi
);
    seq_state_t state_q;
    cmd_t       op_q;
    cmd_t       new_cmd;
    logic       start;
    logic [LINE_W-1:0] wdata_q;

    // Purpose: decide whether a command write launches an access.
    always_comb begin
        new_cmd = cmd_t'(cmd_wdata);
        start   = wr_cmd && new_cmd.go && mem_ok && (state_q == SEQ_IDLE);
    end

    // Purpose: state, stored command and staged write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cmd_q   <= '0;
            op_q    <= '0;
            wdata_q <= '0;
        end else begin
            if (wr_cmd && (state_q == SEQ_IDLE)) begin
                cmd_q <= cmd_wdata;
            end
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_ISSUE;
                        op_q    <= new_cmd;
                        wdata_q <= new_cmd.tag ? {{WORD_W{1'b0}}, dlo_q} : {dhi_q, dlo_q};
                    end
                end
                SEQ_ISSUE:   state_q <= SEQ_CAPTURE;
                SEQ_CAPTURE: state_q <= SEQ_IDLE;
                default:     state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Purpose: array port and capture enables from state.
    always_comb begin
        busy      = (state_q != SEQ_IDLE);
        arr_req   = (state_q == SEQ_ISSUE);
        arr_we    = op_q.write;
        arr_tag   = op_q.tag;
        arr_way   = op_q.way;
        arr_set   = op_q.set;
        arr_wdata = wdata_q;
        cap_lo    = (state_q == SEQ_CAPTURE) && !op_q.write;
        cap_hi    = (state_q == SEQ_CAPTURE) && !op_q.write && !op_q.tag;
    end
endmodule

// File: rtl/ctp_datareg.sv
// Module: the two 32-bit data registers. Array capture takes
// precedence over a bus write in the same cycle.
module ctp_datareg
    import ctp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_dlo,
    input  logic                  wr_dhi,
    input  logic [WORD_W-1:0]     bus_wdata,
    input  logic                  cap_lo,
    input  logic                  cap_hi,
    input  logic [LINE_W-1:0]     arr_rdata,
    output logic [WORD_W-1:0]     dlo_q,
    output logic [WORD_W-1:0]     dhi_q
);
    // Purpose: low data register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      dlo_q <= '0;
        else if (cap_lo) dlo_q <= arr_rdata[WORD_W-1:0];
        else if (wr_dlo) dlo_q <= bus_wdata;
    end

    // Purpose: high data register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      dhi_q <= '0;
        else if (cap_hi) dhi_q <= arr_rdata[LINE_W-1:WORD_W];
        else if (wr_dhi) dhi_q <= bus_wdata;
    end
endmodule

// File: rtl/cache_test_port.sv
// Module: top of the cache array test port. Ties bus decode, the
// sequencer and the data registers together and forms the enable gate.
module cache_test_port
    import ctp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    input  logic                  bus_priv,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  bus_err,
    input  logic                  mc_mem_en,
    input  logic [1:0]            mc_cfg,
    input  logic                  mc_prot_en,
    output logic                  arr_req,
    output logic                  arr_we,
    output logic                  arr_tag,
    output logic [WAY_W-1:0]      arr_way,
    output logic [SET_W-1:0]      arr_set,
    output logic [LINE_W-1:0]     arr_wdata,
    input  logic [LINE_W-1:0]     arr_rdata
);
    logic              wr_cmd, wr_dlo, wr_dhi;
    logic              busy, mem_ok, cap_lo, cap_hi;
    logic [CMD_W-1:0]  cmd_q;
    logic [WORD_W-1:0] dlo_q, dhi_q;

    // Purpose: memory-control enable gate.
    always_comb mem_ok = mc_mem_en && (mc_cfg == MC_CFG_CACHE) && !mc_prot_en;

    ctp_regbus u_bus (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_priv(bus_priv), .busy(busy), .cmd_q(cmd_q),
        .dlo_q(dlo_q), .dhi_q(dhi_q), .wr_cmd(wr_cmd),
        .wr_dlo(wr_dlo), .wr_dhi(wr_dhi), .bus_rdata(bus_rdata),
        .bus_err(bus_err)
    );

    ctp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd),
        .cmd_wdata(bus_wdata[CMD_W-1:0]), .mem_ok(mem_ok),
        .dlo_q(dlo_q), .dhi_q(dhi_q), .cmd_q(cmd_q), .busy(busy),
        .arr_req(arr_req), .arr_we(arr_we), .arr_tag(arr_tag),
        .arr_way(arr_way), .arr_set(arr_set), .arr_wdata(arr_wdata),
        .cap_lo(cap_lo), .cap_hi(cap_hi)
    );

    ctp_datareg u_dreg (
        .clk(clk), .rst_n(rst_n), .wr_dlo(wr_dlo), .wr_dhi(wr_dhi),
        .bus_wdata(bus_wdata), .cap_lo(cap_lo), .cap_hi(cap_hi),
        .arr_rdata(arr_rdata), .dlo_q(dlo_q), .dhi_q(dhi_q)
    );
endmodule

// File: rtl/ctp_checker.sv
// Module: protocol checks on the test port, bound to the top module.
module ctp_checker
    import ctp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_go,
    input logic              bus_priv,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              mc_mem_en,
    input logic [1:0]        mc_cfg,
    input logic              mc_prot_en,
    input logic              arr_req
);
    a_r1_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> !arr_req);

    a_r1_no_go_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_CMD && !bus_go) |=> !arr_req);

    a_r6_user_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_priv) |=> !arr_req);

    a_r6_user_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !bus_priv) |-> (bus_rdata == '0 && bus_err));

    a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_CMD &&
         !(mc_mem_en && mc_cfg == MC_CFG_CACHE && !mc_prot_en)) |=> !arr_req);
endmodule

bind cache_test_port ctp_checker chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_go(bus_wdata[0]), .bus_priv(bus_priv),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .mc_mem_en(mc_mem_en),
    .mc_cfg(mc_cfg), .mc_prot_en(mc_prot_en), .arr_req(arr_req)
);

// File: tb/cache_test_port_tb_top.sv
// Directed bench for the cache array test port with RAM models.
module cache_test_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        mc_mem_en = 1'b1, mc_prot_en = 1'b0;
    logic [1:0]  mc_cfg = 2'b11;
    logic        arr_req, arr_we, arr_tag;
    logic [1:0]  arr_way;
    logic [10:0] arr_set;
    logic [63:0] arr_wdata;
    logic [63:0] arr_rdata = '0;

    int checks = 0;
    int fails = 0;

    logic [63:0] dmem [64];
    logic [31:0] tmem [64];

    always #10 clk = ~clk;

    cache_test_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .mc_mem_en(mc_mem_en),
        .mc_cfg(mc_cfg), .mc_prot_en(mc_prot_en), .arr_req(arr_req),
        .arr_we(arr_we), .arr_tag(arr_tag), .arr_way(arr_way),
        .arr_set(arr_set), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    // synchronous RAM models, one cycle read latency
    always @(posedge clk) begin
        if (arr_req) begin
            if (arr_tag) begin
                if (arr_we) tmem[{arr_way, arr_set[3:0]}] <= arr_wdata[31:0];
                arr_rdata <= {32'hFFFF_FFFF, tmem[{arr_way, arr_set[3:0]}]};
            end else begin
                if (arr_we) dmem[{arr_way, arr_set[3:0]}] <= arr_wdata;
                arr_rdata <= dmem[{arr_way, arr_set[3:0]}];
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input logic wr, input logic tg,
                                           input logic [1:0] way, input logic [10:0] set);
        return {16'h0, set, way, tg, wr, 1'b1};
    endfunction

    // called at a negedge, returns at the following negedge
    task automatic bwrite(input logic [1:0] a, input logic [31:0] d, input logic pr);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = pr;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic bread(input logic [1:0] a, input logic pr,
                         output logic [31:0] d, output logic e);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_priv = pr;
        #1;
        d = bus_rdata; e = bus_err;
        bus_sel = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        bread(2'd0, 1'b1, d, e); chk("R10 cmd", {32'h0, d}, 64'h0);
        bread(2'd1, 1'b1, d, e); chk("R10 dlo", {32'h0, d}, 64'h0);
        bread(2'd2, 1'b1, d, e); chk("R10 dhi", {32'h0, d}, 64'h0);
        chk("R10 arr_req", {63'h0, arr_req}, 64'h0);
    endtask

    task automatic t_data_rw();
        logic [31:0] d; logic e;
        bwrite(2'd1, 32'h1111_2222, 1'b1);
        bwrite(2'd2, 32'h3333_4444, 1'b1);
        bwrite(2'd0, mk_cmd(1'b1, 1'b0, 2'd1, 11'd3), 1'b1);
        chk("R1 req", {63'h0, arr_req}, 64'h1);
        chk("R2 fields", {49'h0, arr_we, arr_tag, arr_way, arr_set}, {49'h0, 1'b1, 1'b0, 2'd1, 11'd3});
        chk("R3 wdata", arr_wdata, 64'h3333_4444_1111_2222);
        @(negedge clk);
        chk("R1 one pulse", {63'h0, arr_req}, 64'h0);
        @(negedge clk);
        bwrite(2'd1, 32'h0, 1'b1);
        bwrite(2'd2, 32'hAAAA_0000, 1'b1);
        bwrite(2'd0, mk_cmd(1'b0, 1'b0, 2'd1, 11'd3), 1'b1);
        bread(2'd0, 1'b1, d, e); chk("R8 busy", {63'h0, d[31]}, 64'h1);
        bread(2'd2, 1'b1, d, e); chk("R8 old data", {32'h0, d}, 64'h0000_0000_AAAA_0000);
        @(negedge clk);
        bread(2'd0, 1'b1, d, e); chk("R8 still busy", {63'h0, d[31]}, 64'h1);
        @(negedge clk);
        bread(2'd0, 1'b1, d, e); chk("R8 done", {32'h0, d}, {48'h0, mk_cmd(1'b0, 1'b0, 2'd1, 11'd3)});
        bread(2'd1, 1'b1, d, e); chk("R4 dlo", {32'h0, d}, 64'h1111_2222);
        bread(2'd2, 1'b1, d, e); chk("R4 dhi", {32'h0, d}, 64'h3333_4444);
        bwrite(2'd0, mk_cmd(1'b0, 1'b0, 2'd2, 11'd3), 1'b1);
        @(negedge clk); @(negedge clk);
        bread(2'd1, 1'b1, d, e); chk("R2 way select", {32'h0, d}, 64'h0);
    endtask

    task automatic t_tag();
        logic [31:0] d; logic e;
        bwrite(2'd1, 32'h00C0_FFEE, 1'b1);
        bwrite(2'd2, 32'h5555_5555, 1'b1);
        bwrite(2'd0, mk_cmd(1'b1, 1'b1, 2'd0, 11'd5), 1'b1);
        chk("R5 tag wdata", arr_wdata, 64'h0000_0000_00C0_FFEE);
        @(negedge clk); @(negedge clk);
        bwrite(2'd1, 32'h0, 1'b1);
        bwrite(2'd2, 32'h7777_1234, 1'b1);
        bwrite(2'd0, mk_cmd(1'b0, 1'b1, 2'd0, 11'd5), 1'b1);
        @(negedge clk); @(negedge clk);
        bread(2'd1, 1'b1, d, e); chk("R5 tag dlo", {32'h0, d}, 64'h00C0_FFEE);
        bread(2'd2, 1'b1, d, e); chk("R5 dhi kept", {32'h0, d}, 64'h7777_1234);
    endtask

    task automatic t_priv();
        logic [31:0] d; logic e;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'hDEAD_0001; bus_priv = 1'b0;
        #1; chk("R6 write err", {63'h0, bus_err}, 64'h1);
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
        bread(2'd1, 1'b1, d, e); chk("R6 write dropped", {32'h0, d}, 64'h00C0_FFEE);
        bread(2'd1, 1'b0, d, e); chk("R6 user read", {31'h0, e, d}, {31'h0, 1'b1, 32'h0});
        bwrite(2'd0, mk_cmd(1'b1, 1'b0, 2'd0, 11'd0), 1'b0);
        chk("R6 no access", {63'h0, arr_req}, 64'h0);
    endtask

    task automatic t_gate(input logic en, input logic [1:0] cfg, input logic prot, input string req);
        mc_mem_en = en; mc_cfg = cfg; mc_prot_en = prot;
        bwrite(2'd0, mk_cmd(1'b1, 1'b0, 2'd0, 11'd9), 1'b1);
        chk(req, {63'h0, arr_req}, 64'h0);
        mc_mem_en = 1'b1; mc_cfg = 2'b11; mc_prot_en = 1'b0;
    endtask

    task automatic t_nogo();
        bwrite(2'd0, 32'h0000_0022, 1'b1);
        chk("R1 go clear", {63'h0, arr_req}, 64'h0);
    endtask

    task automatic t_busy_drop();
        logic [31:0] d; logic e;
        bwrite(2'd0, mk_cmd(1'b0, 1'b0, 2'd1, 11'd3), 1'b1);
        bwrite(2'd0, mk_cmd(1'b1, 1'b1, 2'd3, 11'd7), 1'b1);
        chk("R9 no second req", {63'h0, arr_req}, 64'h0);
        @(negedge clk);
        bread(2'd0, 1'b1, d, e); chk("R9 cmd kept", {32'h0, d}, {48'h0, mk_cmd(1'b0, 1'b0, 2'd1, 11'd3)});
    endtask

    task automatic t_addr3();
        logic [31:0] d; logic e;
        bwrite(2'd3, 32'hFFFF_FFFF, 1'b1);
        bread(2'd3, 1'b1, d, e); chk("R11 addr3", {31'h0, e, d}, 64'h0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin dmem[i] = '0; tmem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_rw();
        t_tag();
        t_priv();
        t_gate(1'b0, 2'b11, 1'b0, "R7 mem off");
        t_gate(1'b1, 2'b10, 1'b0, "R7 cfg");
        t_gate(1'b1, 2'b11, 1'b1, "R7 prot on");
        t_nogo();
        t_busy_drop();
        t_addr3();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule